// File: doc/BRIEF.md
# Chained Sprite Row Loader

This block moves bitmap bytes from a central video controller to eight sprite stages without a wide parallel bus. The controller places one delivery word at the head of a relay chain. The word carries a valid flag, the number of the target sprite, the byte slot within that sprite's row and eight data bits. Every stage holds the word in a register for one cycle and then passes it on. The stage whose number matches the word keeps the byte in its three-byte row buffer. A word that enters the head shows up at the tail output eight cycles later.

A stage treats its row buffer as complete only once the last byte slot has been written. At the next line-start pulse it copies a complete buffer into its line register, which the pixel drawing logic reads. A second chain runs the other way. Each sprite uses it to report the row inside the sprite that it will draw next, so that the controller knows which three bytes to fetch. A report moves one hop per cycle toward the controller. Reports that are already travelling toward the controller go ahead of new ones. A stage that has to wait keeps its report and sends it when the path is free.

Top module: `spr_chain`

## Requirements
- R1: The head takes one delivery word made of `head_valid`, a 3-bit sprite number `head_idx` (0 to 7), a 2-bit byte slot `head_slot` and 8-bit `head_data`. With `head_valid` low the word does nothing.
- R2: Each stage registers the word and hands it on unchanged, even when the word was meant for that stage. A word applied before clock edge k shows on the `tail_*` outputs after edge k+7, which is eight register stages.
- R3: Only the stage whose number equals `head_idx` stores the byte. Every other sprite's row buffer and line register stay unchanged.
- R4: Slot values 0, 1 and 2 pick a byte. Slot value 3 stores nothing and does not mark the buffer complete.
- R5: A buffer becomes complete only when slot 2 is written. Writing only slots 0 and 1 leaves it incomplete.
- R6: On a `line_start` edge, a stage with a complete buffer copies it into its 24-bit slice of `line_bits`, with slot 0 in bits [7:0], slot 1 in [15:8] and slot 2 in [23:16]. It raises its `line_loaded` bit and clears the complete mark. A stage without a complete buffer keeps its old `line_bits` and drops `line_loaded`.
- R7: If a slot 2 write and `line_start` fall on the same edge, the copy takes the buffer contents from before that write. The new byte stays in the buffer and makes it complete for the following line.
- R8: Sprite n reports a row by raising `rpt_valid[n]` with `rpt_row[n*5 +: 5]`. When nothing blocks the path, the report shows on `ret_valid`, `ret_idx` and `ret_row` after n+1 clock edges.
- R9: A report already moving on the return chain goes ahead of a stage's own report. The blocked report is held and sent on the first free cycle. A newer report from the same sprite replaces the held one, so only the latest row is sent.
- R10: A synchronous active-low reset clears all chain registers, buffers, complete marks, line registers, `line_loaded` and held reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| head_valid | input | 1 | Delivery word valid at head |
| head_idx | input | 3 | Target sprite number |
| head_slot | input | 2 | Byte slot within the row |
| head_data | input | 8 | Bitmap byte |
| line_start | input | 1 | Start of a new raster line |
| rpt_valid | input | 8 | Per-sprite row report strobe |
| rpt_row | input | 40 | Per-sprite row numbers, 5 bits each |
| ret_valid | output | 1 | Row report valid at controller end |
| ret_idx | output | 3 | Sprite that sent the report |
| ret_row | output | 5 | Reported row |
| tail_valid | output | 1 | Delivery word valid at chain tail |
| tail_idx | output | 3 | Tail word sprite number |
| tail_slot | output | 2 | Tail word slot |
| tail_data | output | 8 | Tail word data |
| line_bits | output | 192 | Per-sprite line registers, 24 bits each |
| line_loaded | output | 8 | Per-sprite flag that this line got fresh data |

## Verification
Delivery is tried on a word for sprite 0, which must still reach the tail, and on bytes for one sprite in the middle of the chain, with its neighbours watched so that a wrong match shows up. Partial rows, a slot 3 write and a slot 2 write that lands on the line-start edge separate a buffer marked complete too early from one copied at the wrong time. On the return side, a report from the nearest sprite, one from the far end and two reports that meet in the chain expose wrong hop counts, lost reports and stale rows that were never replaced.

// File: rtl/spr_chain_pkg.sv
package spr_chain_pkg;
  parameter int NUM_SPR = 8;
  parameter int DATA_W  = 8;
  parameter int BYTES   = 3;
  parameter int ROW_W   = 5;
  localparam int IDX_W  = $clog2(NUM_SPR);
  localparam int SLOT_W = $clog2(BYTES + 1);
  localparam int LINE_W = BYTES * DATA_W;

  typedef struct packed {
    logic              valid;
    logic [IDX_W-1:0]  idx;
    logic [SLOT_W-1:0] slot;
    logic [DATA_W-1:0] data;
  } dlv_word_t;

  typedef struct packed {
    logic              valid;
    logic [IDX_W-1:0]  idx;
    logic [ROW_W-1:0]  row;
  } ret_word_t;

  function automatic logic slot_in_range(input logic [SLOT_W-1:0] s);
    return int'(s) < BYTES;
  endfunction

  function automatic logic slot_is_last(input logic [SLOT_W-1:0] s);
    return int'(s) == BYTES - 1;
  endfunction

  function automatic logic word_targets(input dlv_word_t w, input int stage);
    return w.valid && (int'(w.idx) == stage);
  endfunction
endpackage

// File: rtl/spr_dlv_hop.sv
module spr_dlv_hop
  import spr_chain_pkg::*;
#(
  parameter int STAGE_ID = 0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  dlv_word_t dlv_in,
  output dlv_word_t dlv_out,
  output logic      wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [DATA_W-1:0] wr_data
);
  dlv_word_t hop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hop_q <= '0;
    else        hop_q <= dlv_in;
  end

  assign dlv_out = hop_q;
  assign wr_en   = word_targets(dlv_in, STAGE_ID) && slot_in_range(dlv_in.slot);
  assign wr_slot = dlv_in.slot;
  assign wr_data = dlv_in.data;

  AST_FWD_ONE_HOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (dlv_out == $past(dlv_in))); // R2
endmodule

// File: rtl/spr_row_buf.sv
module spr_row_buf
  import spr_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_start,
  output logic [LINE_W-1:0] line_bits,
  output logic              line_loaded
);
  logic [BYTES-1:0][DATA_W-1:0] bytes_q;
  logic [LINE_W-1:0]            line_q;
  logic                         ready_q;
  logic                         loaded_q;
  logic                         swap;
  logic                         wr_last;

  assign swap    = line_start && ready_q;
  assign wr_last = wr_en && slot_is_last(wr_slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bytes_q  <= '0;
      line_q   <= '0;
      ready_q  <= 1'b0;
      loaded_q <= 1'b0;
    end else begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_en && (int'(wr_slot) == b)) bytes_q[b] <= wr_data;
      end
      if (line_start) loaded_q <= ready_q;
      if (swap) line_q <= bytes_q;
      if (wr_last)   ready_q <= 1'b1;
      else if (swap) ready_q <= 1'b0;
    end
  end

  assign line_bits   = line_q;
  assign line_loaded = loaded_q;

  AST_READY_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(wr_en && slot_is_last(wr_slot))); // R5
  AST_SWAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && ready_q && !wr_last) |=> !ready_q); // R6
  AST_BUF_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bytes_q)); // R3
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_start && ready_q) |=> $stable(line_q)); // R6
endmodule

// File: rtl/spr_ret_hop.sv
module spr_ret_hop
  import spr_chain_pkg::*;
#(
  parameter int STAGE_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ret_word_t        ret_in,
  input  logic             rpt_v,
  input  logic [ROW_W-1:0] rpt_row,
  output ret_word_t        ret_out
);
  ret_word_t        ret_q;
  logic             pend_v;
  logic [ROW_W-1:0] pend_row;
  logic             have_own;
  logic [ROW_W-1:0] own_row;
  logic             blocked;

  assign have_own = rpt_v || pend_v;
  assign own_row  = rpt_v ? rpt_row : pend_row;
  assign blocked  = ret_in.valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_q    <= '0;
      pend_v   <= 1'b0;
      pend_row <= '0;
    end else if (blocked) begin
      ret_q    <= ret_in;
      pend_v   <= have_own;
      pend_row <= own_row;
    end else if (have_own) begin
      ret_q.valid <= 1'b1;
      ret_q.idx   <= IDX_W'(STAGE_ID);
      ret_q.row   <= own_row;
      pend_v      <= 1'b0;
    end else begin
      ret_q.valid <= 1'b0;
    end
  end

  assign ret_out = ret_q;

  AST_RET_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    ret_in.valid |=> (ret_out == $past(ret_in))); // R9
  AST_RET_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_v && ret_in.valid) |=> pend_v); // R9
  AST_RET_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !ret_in.valid) |=> (ret_out.valid && !pend_v)); // R8
endmodule

// File: rtl/spr_stage.sv
module spr_stage
  import spr_chain_pkg::*;
#(
  parameter int STAGE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dlv_word_t         dlv_in,
  output dlv_word_t         dlv_out,
  input  ret_word_t         ret_in,
  output ret_word_t         ret_out,
  input  logic              rpt_v,
  input  logic [ROW_W-1:0]  rpt_row,
  input  logic              line_start,
  output logic [LINE_W-1:0] line_bits,
  output logic              line_loaded
);
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [DATA_W-1:0] wr_data;

  spr_dlv_hop #(.STAGE_ID(STAGE_ID)) u_dlv (
    .clk(clk), .rst_n(rst_n), .dlv_in(dlv_in), .dlv_out(dlv_out),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data)
  );

  spr_row_buf u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(wr_data), .line_start(line_start),
    .line_bits(line_bits), .line_loaded(line_loaded)
  );

  spr_ret_hop #(.STAGE_ID(STAGE_ID)) u_ret (
    .clk(clk), .rst_n(rst_n), .ret_in(ret_in), .rpt_v(rpt_v),
    .rpt_row(rpt_row), .ret_out(ret_out)
  );
endmodule

// File: rtl/spr_chain.sv
module spr_chain
  import spr_chain_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       head_valid,
  input  logic [IDX_W-1:0]           head_idx,
  input  logic [SLOT_W-1:0]          head_slot,
  input  logic [DATA_W-1:0]          head_data,
  input  logic                       line_start,
  input  logic [NUM_SPR-1:0]         rpt_valid,
  input  logic [NUM_SPR*ROW_W-1:0]   rpt_row,
  output logic                       ret_valid,
  output logic [IDX_W-1:0]           ret_idx,
  output logic [ROW_W-1:0]           ret_row,
  output logic                       tail_valid,
  output logic [IDX_W-1:0]           tail_idx,
  output logic [SLOT_W-1:0]          tail_slot,
  output logic [DATA_W-1:0]          tail_data,
  output logic [NUM_SPR*LINE_W-1:0]  line_bits,
  output logic [NUM_SPR-1:0]         line_loaded
);
  dlv_word_t dlv_w [NUM_SPR+1];
  ret_word_t ret_w [NUM_SPR+1];

  assign dlv_w[0] = '{valid: head_valid, idx: head_idx, slot: head_slot, data: head_data};
  assign ret_w[NUM_SPR] = '0;

  for (genvar i = 0; i < NUM_SPR; i++) begin : g_stage
    spr_stage #(.STAGE_ID(i)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .dlv_in(dlv_w[i]), .dlv_out(dlv_w[i+1]),
      .ret_in(ret_w[i+1]), .ret_out(ret_w[i]),
      .rpt_v(rpt_valid[i]), .rpt_row(rpt_row[i*ROW_W +: ROW_W]),
      .line_start(line_start),
      .line_bits(line_bits[i*LINE_W +: LINE_W]),
      .line_loaded(line_loaded[i])
    );
  end

  assign ret_valid  = ret_w[0].valid;
  assign ret_idx    = ret_w[0].idx;
  assign ret_row    = ret_w[0].row;
  assign tail_valid = dlv_w[NUM_SPR].valid;
  assign tail_idx   = dlv_w[NUM_SPR].idx;
  assign tail_slot  = dlv_w[NUM_SPR].slot;
  assign tail_data  = dlv_w[NUM_SPR].data;

  AST_LOADED_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(line_loaded)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (line_loaded == '0 && !ret_valid && !tail_valid)); // R10
endmodule

// File: tb/spr_chain_tb.sv
module spr_chain_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        head_valid = 1'b0;
  logic [2:0]  head_idx = '0;
  logic [1:0]  head_slot = '0;
  logic [7:0]  head_data = '0;
  logic        line_start = 1'b0;
  logic [7:0]  rpt_valid = '0;
  logic [39:0] rpt_row = '0;
  logic        ret_valid, tail_valid;
  logic [2:0]  ret_idx, tail_idx;
  logic [4:0]  ret_row;
  logic [1:0]  tail_slot;
  logic [7:0]  tail_data;
  logic [191:0] line_bits;
  logic [7:0]  line_loaded;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spr_chain u_dut (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_idx(head_idx),
    .head_slot(head_slot), .head_data(head_data), .line_start(line_start),
    .rpt_valid(rpt_valid), .rpt_row(rpt_row), .ret_valid(ret_valid),
    .ret_idx(ret_idx), .ret_row(ret_row), .tail_valid(tail_valid),
    .tail_idx(tail_idx), .tail_slot(tail_slot), .tail_data(tail_data),
    .line_bits(line_bits), .line_loaded(line_loaded)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [23:0] row_of(input int s);
    return line_bits[s*24 +: 24];
  endfunction

  task automatic send(input int s, input int slot, input logic [7:0] d);
    head_valid = 1'b1; head_idx = 3'(s); head_slot = 2'(slot); head_data = d;
    tick();
    head_valid = 1'b0;
  endtask

  task automatic pulse_line();
    line_start = 1'b1;
    tick();
    line_start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 line_loaded", 64'(line_loaded), 64'h0);
    chk("R10 line_bits", 64'(|line_bits), 64'h0);
    chk("R10 ret_valid", 64'(ret_valid), 64'h0);
    chk("R10 tail_valid", 64'(tail_valid), 64'h0);
  endtask

  task automatic t_tail_latency();
    head_valid = 1'b1; head_idx = 3'd0; head_slot = 2'd1; head_data = 8'hA5;
    tick();
    head_valid = 1'b0;
    tick(6);
    chk("R2 tail not early", 64'(tail_valid), 64'h0);
    tick();
    chk("R2 tail after 8", {tail_valid, tail_idx, tail_slot, tail_data}, {1'b1, 3'd0, 2'd1, 8'hA5});
    tick();
    chk("R1 single word", 64'(tail_valid), 64'h0);
  endtask

  task automatic t_partial_and_full();
    send(4, 0, 8'h11); send(4, 1, 8'h22); tick(9);
    pulse_line();
    chk("R5 partial not loaded", 64'(line_loaded[4]), 64'h0);
    chk("R5 partial keeps bits", 64'(row_of(4)), 64'h0);
    send(4, 2, 8'h33); tick(9);
    pulse_line();
    chk("R6 loaded flag", 64'(line_loaded), 64'h10);
    chk("R6 line bits", 64'(row_of(4)), 64'h332211);
    chk("R3 neighbour 3 untouched", 64'(row_of(3)), 64'h0);
    chk("R3 neighbour 5 untouched", 64'(row_of(5)), 64'h0);
    pulse_line();
    chk("R6 no ready drops flag", 64'(line_loaded[4]), 64'h0);
    chk("R6 bits held", 64'(row_of(4)), 64'h332211);
  endtask

  task automatic t_slot3();
    send(6, 3, 8'hEE); tick(9);
    pulse_line();
    chk("R4 slot3 no ready", 64'(line_loaded[6]), 64'h0);
    chk("R4 slot3 no bits", 64'(row_of(6)), 64'h0);
  endtask

  task automatic t_same_edge();
    send(0, 0, 8'hA1); send(0, 1, 8'hB2); send(0, 2, 8'hC3); tick(2);
    head_valid = 1'b1; head_idx = 3'd0; head_slot = 2'd2; head_data = 8'hD4;
    line_start = 1'b1;
    tick();
    head_valid = 1'b0; line_start = 1'b0;
    chk("R7 old contents copied", 64'(row_of(0)), 64'hC3B2A1);
    chk("R7 loaded", 64'(line_loaded[0]), 64'h1);
    tick(9);
    pulse_line();
    chk("R7 new byte next line", 64'(row_of(0)), 64'hD4B2A1);
    chk("R7 still ready", 64'(line_loaded[0]), 64'h1);
  endtask

  task automatic t_ret_near();
    rpt_valid[0] = 1'b1; rpt_row[4:0] = 5'd3;
    tick();
    rpt_valid = '0;
    chk("R8 sprite0 report", {ret_valid, ret_idx, ret_row}, {1'b1, 3'd0, 5'd3});
    tick();
    chk("R8 sprite0 single", 64'(ret_valid), 64'h0);
  endtask

  task automatic t_ret_far();
    rpt_valid[5] = 1'b1; rpt_row[25 +: 5] = 5'd17;
    tick();
    rpt_valid = '0;
    tick(4);
    chk("R8 sprite5 not early", 64'(ret_valid), 64'h0);
    tick();
    chk("R8 sprite5 report", {ret_valid, ret_idx, ret_row}, {1'b1, 3'd5, 5'd17});
  endtask

  task automatic t_ret_collide();
    tick(3);
    rpt_valid[3] = 1'b1; rpt_row[15 +: 5] = 5'd12;
    tick();
    rpt_valid = '0;
    rpt_valid[2] = 1'b1; rpt_row[10 +: 5] = 5'd4;
    tick();
    rpt_row[10 +: 5] = 5'd9;
    tick();
    rpt_valid = '0;
    tick();
    chk("R9 upstream first", {ret_valid, ret_idx, ret_row}, {1'b1, 3'd3, 5'd12});
    tick();
    chk("R9 held latest row", {ret_valid, ret_idx, ret_row}, {1'b1, 3'd2, 5'd9});
    tick();
    chk("R9 no stale repeat", 64'(ret_valid), 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_tail_latency();
    t_partial_and_full();
    t_slot3();
    t_same_edge();
    t_ret_near();
    t_ret_far();
    t_ret_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule